// File: doc/BRIEF.md
# Multi-Latency Execution Unit Scheduler

This block tracks instructions that are handed, in program order, one per clock, to a set of execution pipes with different fixed latencies. The pipes are a single-cycle integer unit, a single-cycle memory unit, a two-stage floating-point adder, a six-cycle multiplier that is fully pipelined, and a fifteen-cycle divider that is not pipelined. For each offered instruction the scheduler decides whether it can be taken. It then counts down the instruction's latency and reports its completion tag and destination register through one write-back port. No arithmetic is performed. Only the timing and the bookkeeping of the results are modelled.

Because the latencies differ, operations issued at different times can become ready in the same cycle. All finished operations wait in their tracking slots. Each cycle, the one issued earliest among the ready ones is written back. Issue is held back in three cases: every tracking slot is occupied, the destination register already has a result outstanding, or a second divide is offered while the divider is still held.

Top module: `exu_sched`

## Requirements
- R1: While `rst` is high, and in the cycle after it has been high, `wb_valid` and `busy` are low. No tracking slot is occupied after reset.
- R2: The class codes are 0 for integer (latency 1), 1 for memory (latency 1), 2 for floating-point add (latency 2), 3 for multiply (latency 6) and 4 for divide (latency 15). Codes 5 to 7 are refused. An operation accepted at clock edge t is reported after edge t+L when no older ready result competes with it.
- R3: Multiplies may be accepted on consecutive cycles, up to the slot limit.
- R4: A divide is refused while an earlier divide still occupies a slot, up to and including its write-back edge.
- R5: No more than 6 operations are tracked at once. An offer is refused while all 6 slots are occupied, even if one of them is written back at the same edge.
- R6: An offer is refused while any tracked operation has the same destination register.
- R7: At most one result is written back per cycle. Among ready results, the one accepted earliest goes first, and the others keep waiting.
- R8: Every accepted tag is reported exactly once, together with the destination it was accepted with.
- R9: `busy` is high exactly when at least one slot is occupied.
- R10: `iss_accept` is high only while `iss_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is offered this cycle |
| iss_class | input | 3 | Execution class code of the offer |
| iss_tag | input | TAG_W | Tag of the offered instruction |
| iss_dst | input | REG_W | Destination register of the offered instruction |
| iss_accept | output | 1 | The offer is taken at this clock edge |
| wb_valid | output | 1 | A completion is reported this cycle |
| wb_tag | output | TAG_W | Tag of the completed instruction |
| wb_dst | output | REG_W | Destination of the completed instruction |
| busy | output | 1 | At least one operation is being tracked |

## Verification
The hardest case to reach is several results becoming ready in the same cycle from different pipes. This requires issuing a divide, a multiply, an add and an integer operation at staggered times, chosen so that their counts run out together. A directed sequence issues a divide, waits eight cycles, then issues a multiply, waits three, then issues an add and an integer operation back to back, so that four results become ready at one edge. The order of write-back is then compared against the behavioural model. Back-to-back multiplies fill all six slots to exercise the full and pending-destination refusals. A long random phase with a small destination range produces frequent register conflicts and divide refusals.

// File: rtl/exu_sched_pkg.sv
package exu_sched_pkg;
  typedef enum logic [2:0] {
    CL_INT  = 3'd0,
    CL_MEM  = 3'd1,
    CL_FADD = 3'd2,
    CL_MUL  = 3'd3,
    CL_DIV  = 3'd4
  } op_class_e;
endpackage

// File: rtl/exu_sched_slot.sv
module exu_sched_slot #(
  parameter int TAG_W = 6,
  parameter int REG_W = 5,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic             retire,
  input  logic [CNT_W-1:0] ld_cnt,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [REG_W-1:0] in_dst,
  input  logic             in_div,
  output logic             vld,
  output logic             rdy,
  output logic [TAG_W-1:0] tag_q,
  output logic [REG_W-1:0] dst_q,
  output logic             div_q
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= 1'b0;
      cnt   <= '0;
      tag_q <= '0;
      dst_q <= '0;
      div_q <= 1'b0;
    end else if (alloc) begin
      vld   <= 1'b1;
      cnt   <= ld_cnt;
      tag_q <= in_tag;
      dst_q <= in_dst;
      div_q <= in_div;
    end else begin
      if (retire) vld <= 1'b0;
      if (vld && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign rdy = vld && (cnt == '0);
endmodule

// File: rtl/exu_sched_age.sv
module exu_sched_age #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] alloc,
  input  logic [N-1:0] vld,
  input  logic [N-1:0] rdy,
  output logic [N-1:0] grant
);
  // older[i][j] set: slot j was filled before slot i
  logic [N-1:0] older [N];

  always_comb begin
    for (int i = 0; i < N; i++)
      grant[i] = rdy[i] && ((older[i] & rdy) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) older[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc[i]) older[i] <= vld & ~grant;
        else          older[i] <= older[i] & ~alloc;
      end
    end
  end
endmodule

// File: rtl/exu_sched.sv
module exu_sched
  import exu_sched_pkg::*;
#(
  parameter int N_SLOT   = 6,
  parameter int TAG_W    = 6,
  parameter int REG_W    = 5,
  parameter int LAT_INT  = 1,
  parameter int LAT_MEM  = 1,
  parameter int LAT_FADD = 2,
  parameter int LAT_MUL  = 6,
  parameter int LAT_DIV  = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_valid,
  input  logic [2:0]       iss_class,
  input  logic [TAG_W-1:0] iss_tag,
  input  logic [REG_W-1:0] iss_dst,
  output logic             iss_accept,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag,
  output logic [REG_W-1:0] wb_dst,
  output logic             busy
);
  localparam int CNT_W = $clog2(LAT_DIV + 1);
  localparam int OCC_W = $clog2(N_SLOT + 1);

  logic [N_SLOT-1:0] vld, rdy, div_q, alloc, grant;
  logic [TAG_W-1:0]  tag_q [N_SLOT];
  logic [REG_W-1:0]  dst_q [N_SLOT];
  logic [CNT_W-1:0]  ld_cnt;
  logic              cls_ok, is_div, dst_hit, div_busy, full;
  logic [OCC_W-1:0]  occ_cnt;

  always_comb begin
    cls_ok = 1'b1;
    is_div = 1'b0;
    case (iss_class)
      CL_INT:  ld_cnt = CNT_W'(LAT_INT - 1);
      CL_MEM:  ld_cnt = CNT_W'(LAT_MEM - 1);
      CL_FADD: ld_cnt = CNT_W'(LAT_FADD - 1);
      CL_MUL:  ld_cnt = CNT_W'(LAT_MUL - 1);
      CL_DIV: begin
        ld_cnt = CNT_W'(LAT_DIV - 1);
        is_div = 1'b1;
      end
      default: begin
        ld_cnt = '0;
        cls_ok = 1'b0;
      end
    endcase
  end

  always_comb begin
    occ_cnt = '0;
    dst_hit = 1'b0;
    for (int i = 0; i < N_SLOT; i++) begin
      occ_cnt = occ_cnt + OCC_W'(vld[i]);
      if (vld[i] && dst_q[i] == iss_dst) dst_hit = 1'b1;
    end
  end

  assign full     = (occ_cnt == OCC_W'(N_SLOT));
  assign div_busy = |(vld & div_q);
  assign iss_accept = iss_valid && cls_ok && !full && !dst_hit && !(is_div && div_busy);

  always_comb begin
    logic taken;
    taken = 1'b0;
    alloc = '0;
    for (int i = 0; i < N_SLOT; i++) begin
      if (!vld[i] && !taken) begin
        alloc[i] = iss_accept;
        taken    = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    exu_sched_slot #(.TAG_W(TAG_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .alloc  (alloc[g]),
      .retire (grant[g]),
      .ld_cnt (ld_cnt),
      .in_tag (iss_tag),
      .in_dst (iss_dst),
      .in_div (is_div),
      .vld    (vld[g]),
      .rdy    (rdy[g]),
      .tag_q  (tag_q[g]),
      .dst_q  (dst_q[g]),
      .div_q  (div_q[g])
    );
  end

  exu_sched_age #(.N(N_SLOT)) u_age (
    .clk   (clk),
    .rst   (rst),
    .alloc (alloc),
    .vld   (vld),
    .rdy   (rdy),
    .grant (grant)
  );

  logic [TAG_W-1:0] sel_tag;
  logic [REG_W-1:0] sel_dst;
  always_comb begin
    sel_tag = '0;
    sel_dst = '0;
    for (int i = 0; i < N_SLOT; i++) begin
      if (grant[i]) begin
        sel_tag = sel_tag | tag_q[i];
        sel_dst = sel_dst | dst_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_tag   <= '0;
      wb_dst   <= '0;
    end else begin
      wb_valid <= |grant;
      wb_tag   <= sel_tag;
      wb_dst   <= sel_dst;
    end
  end

  assign busy = |vld;
endmodule

// File: rtl/exu_sched_chk.sv
module exu_sched_chk #(
  parameter int N_SLOT = 6
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         iss_valid,
  input logic [2:0]                   iss_class,
  input logic                         iss_accept,
  input logic                         wb_valid,
  input logic                         busy,
  input logic [$clog2(N_SLOT+1)-1:0]  occ,
  input logic                         div_busy
);
  p_accept_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
    iss_accept |-> iss_valid);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (occ == ($clog2(N_SLOT+1))'(N_SLOT)) |-> !iss_accept);

  p_occ_bound_r5: assert property (@(posedge clk) disable iff (rst)
    occ <= ($clog2(N_SLOT+1))'(N_SLOT));

  p_one_divide_r4: assert property (@(posedge clk) disable iff (rst)
    (iss_accept && iss_class == 3'd4) |-> !div_busy);

  p_bad_class_r2: assert property (@(posedge clk) disable iff (rst)
    (iss_class > 3'd4) |-> !iss_accept);

  p_wb_needs_work_r9: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(busy));

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!wb_valid && !busy));
endmodule

bind exu_sched exu_sched_chk #(.N_SLOT(N_SLOT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .iss_valid  (iss_valid),
  .iss_class  (iss_class),
  .iss_accept (iss_accept),
  .wb_valid   (wb_valid),
  .busy       (busy),
  .occ        (occ_cnt),
  .div_busy   (div_busy)
);

// File: tb/exu_sched_tb.sv
module exu_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       iss_valid = 1'b0;
  logic [2:0] iss_class = '0;
  logic [5:0] iss_tag = '0;
  logic [4:0] iss_dst = '0;
  logic       iss_accept, wb_valid, busy;
  logic [5:0] wb_tag;
  logic [4:0] wb_dst;

  always #(CLK_PERIOD/2) clk = ~clk;

  exu_sched u_dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_class(iss_class),
    .iss_tag(iss_tag), .iss_dst(iss_dst), .iss_accept(iss_accept),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_dst(wb_dst), .busy(busy)
  );

  typedef struct { int tag; int dst; int cls; int rem; } ent_t;
  ent_t q[$];

  int total = 0, bad = 0;
  int tagc = 0, acc_cnt = 0, done_cnt = 0;
  bit exp_v = 0, exp_acc = 0, seen_wb = 0;
  int exp_tag = 0, exp_dst = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int lat(input int c);
    case (c)
      0, 1: return 1;
      2: return 2;
      3: return 6;
      4: return 15;
      default: return 0;
    endcase
  endfunction

  function automatic int reason(input bit v, input int c, input int d);
    if (!v) return 1;
    if (c > 4) return 2;
    if (q.size() >= NSLOT) return 3;
    foreach (q[i]) if (q[i].dst == d) return 4;
    if (c == 4) foreach (q[i]) if (q[i].cls == 4) return 5;
    return 0;
  endfunction

  task automatic step(input bit v, input int c, input int d);
    int r, idx;
    string lbl;
    @(negedge clk);
    check(wb_valid == exp_v, "R7 wb_valid", int'(wb_valid), int'(exp_v));
    if (exp_v) begin
      check(int'(wb_tag) == exp_tag, "R8 wb_tag", int'(wb_tag), exp_tag);
      check(int'(wb_dst) == exp_dst, "R8 wb_dst", int'(wb_dst), exp_dst);
    end
    check(busy == (q.size() > 0), "R9 busy", int'(busy), int'(q.size() > 0));
    seen_wb = wb_valid;
    if (wb_valid) done_cnt++;
    iss_valid = v;
    iss_class = 3'(c);
    iss_dst   = 5'(d);
    iss_tag   = 6'(tagc);
    #1;
    r = reason(v, c, d);
    exp_acc = (r == 0);
    case (r)
      1: lbl = "R10 accept";
      2: lbl = "R2 bad class";
      3: lbl = "R5 full";
      4: lbl = "R6 dst pending";
      5: lbl = "R4 divide held";
      default: lbl = (c == 3) ? "R3 accept" : "R2 accept";
    endcase
    check(iss_accept == exp_acc, lbl, int'(iss_accept), int'(exp_acc));
    @(posedge clk);
    exp_v = 0;
    idx = -1;
    foreach (q[i]) begin
      if (q[i].rem == 0) begin
        if (idx < 0) idx = i;
      end else q[i].rem--;
    end
    if (idx >= 0) begin
      exp_v = 1;
      exp_tag = q[idx].tag;
      exp_dst = q[idx].dst;
      q.delete(idx);
    end
    if (exp_acc) begin
      ent_t e;
      e.tag = tagc % 64; e.dst = d; e.cls = c; e.rem = lat(c) - 1;
      q.push_back(e);
      tagc++;
      acc_cnt++;
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 60 && q.size() > 0; k++) step(0, 0, 0);
    step(0, 0, 0);
    step(0, 0, 0);
  endtask

  task automatic measure(input int c, input int d);
    int n;
    step(1, c, d);
    n = 0;
    for (int k = 0; k < 40; k++) begin
      step(0, 0, 0);
      n++;
      if (seen_wb) break;
    end
    check(n - 1 == lat(c), "R2 latency", n - 1, lat(c));
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(wb_valid == 0, "R1 wb_valid in reset", int'(wb_valid), 0);
    check(busy == 0, "R1 busy in reset", int'(busy), 0);
    rst = 1'b0;
    step(0, 0, 0);

    // R2: latency of each class when alone
    for (int c = 0; c < 5; c++) measure(c, c + 1);
    // R2: unused class codes
    step(1, 5, 1); step(1, 7, 2);
    drain();

    // R7: four results ready at one edge, oldest first
    step(1, 4, 1);
    repeat (8) step(0, 0, 0);
    step(1, 3, 2);
    repeat (3) step(0, 0, 0);
    step(1, 2, 3);
    step(1, 0, 4);
    drain();

    // R3, R5, R6: fill with multiplies, then offer more
    for (int k = 0; k < 6; k++) step(1, 3, 10 + k);
    step(1, 0, 20);   // R5 refused, all slots held
    step(1, 1, 11);   // R6 refused, dst 11 still pending
    drain();

    // R4: second divide refused while the first is held
    step(1, 4, 1);
    step(1, 4, 2);
    step(1, 0, 3);
    drain();

    // R10: an offer with valid low
    step(0, 3, 9);
    drain();

    // random phase
    for (int k = 0; k < 3000; k++)
      step(($urandom % 10) < 7, $urandom % 6, $urandom % 8);
    drain();

    check(done_cnt == acc_cnt, "R8 completions vs accepts", done_cnt, acc_cnt);
    check(q.size() == 0, "R8 all drained", q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule